// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer with Page-Hit Detection

This block sits between a bus master and a DRAM controller's pin drivers. It takes a 32-bit byte address and splits it into a 16-bit row field and a column field. The row field goes to the shared DRAM address pins in the row phase, and the column field goes out in the column phase. The split point follows a 4-bit page-geometry code that can change at run time. A bus-width select chooses between an 8-bit and a 16-bit data bus. In 16-bit mode the DRAM is addressed in halfwords, so the byte address is shifted right by one before the split.

The block also keeps the page of the most recent valid access. From it, the block reports whether a new access falls in the same open DRAM page. A hit lets the controller use fast page mode and skip reopening the row.

A page-close request, a change of geometry or width, a reserved code, and reset all forget the stored page. The page-hit flag and the pin address are combinational on the current inputs. The stored page updates on the clock edge that ends a valid access.

Top module: `dram_addr_mux`

## Requirements
- R1: Geometry codes 0, 1, 2 and 3 put the lowest row bit at position 8, 9, 10 and 12 of the effective address. These give pages of 256, 512, 1024 and 4096 locations.
- R2: When `row_phase` is 1, `pin_addr` equals the 16 effective-address bits starting at the lowest row bit.
- R3: When `row_phase` is 0, `pin_addr` equals the effective-address bits below the lowest row bit, with zeros above them.
- R4: With `bus16` = 0 the effective address is the byte address. With `bus16` = 1 it is the byte address shifted right by one.
- R5: Codes 4 to 15 are reserved. While one is applied, `cfg_err` is 1, `pin_addr` is 0 and `page_hit` is 0. Otherwise `cfg_err` is 0.
- R6: With `acc_valid` high, `page_hit` is 1 exactly when a page is stored and the current byte address matches it over the compare range. The compare range is bits 31 down to 8, 9, 10 or 12 (by code) for an 8-bit bus, and 31 down to 9, 10, 11 or 13 for a 16-bit bus. Each valid access on a non-reserved code stores its page at the clock edge.
- R7: When `acc_valid` is low, `page_hit` is 0.
- R8: A cycle with `page_close` high clears the stored page at its clock edge. This holds even if an access is made in the same cycle. The next access is a miss.
- R9: If the code or `bus16` differs from its value in the previous cycle, `page_hit` is 0 in that cycle. The stored page is cleared unless an access in that cycle stores a new one.
- R10: Synchronous reset clears the stored page, so `page_hit` is 0 after reset until a new page is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 32 | Byte address from the bus master |
| page_code | input | 4 | Page geometry code (0 to 3 valid, others reserved) |
| bus16 | input | 1 | 1 = 16-bit data bus, 0 = 8-bit |
| acc_valid | input | 1 | Access present this cycle |
| page_close | input | 1 | Forget the stored page |
| row_phase | input | 1 | 1 = drive row field, 0 = drive column field |
| pin_addr | output | 16 | Multiplexed DRAM address |
| page_hit | output | 1 | Access falls in the stored open page |
| cfg_err | output | 1 | Reserved geometry code applied |

## Verification
`pin_addr`, `cfg_err` and `page_hit` are combinational on the current inputs. The bench drives inputs just after a falling edge and samples them one time unit later, within the same cycle. The stored page changes only at the next rising edge. Its effect is therefore checked on the following access, one cycle later. This applies to a stored tag, a close request, a configuration change and reset alike. Each such check is placed after that edge has passed.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int ADDR_W   = 32;
    localparam int PIN_W    = 16;
    localparam int CODE_W   = 4;
    localparam int SHIFT_W  = $clog2(ADDR_W);

    typedef enum logic [CODE_W-1:0] {
        GEO_256  = 4'd0,
        GEO_512  = 4'd1,
        GEO_1K   = 4'd2,
        GEO_4K   = 4'd3
    } geo_code_e;

    typedef struct packed {
        logic               ok;
        logic [SHIFT_W-1:0] row_lsb;
        logic [SHIFT_W-1:0] hit_lsb;
    } geom_t;

    function automatic geom_t decode_geom(logic [CODE_W-1:0] code, logic wide);
        geom_t g;
        g.ok      = 1'b1;
        unique case (code)
            GEO_256: g.row_lsb = SHIFT_W'(8);
            GEO_512: g.row_lsb = SHIFT_W'(9);
            GEO_1K:  g.row_lsb = SHIFT_W'(10);
            GEO_4K:  g.row_lsb = SHIFT_W'(12);
            default: begin
                g.ok      = 1'b0;
                g.row_lsb = '0;
            end
        endcase
        g.hit_lsb = g.row_lsb + SHIFT_W'(wide);
        return g;
    endfunction

    function automatic logic [ADDR_W-1:0] low_mask(logic [SHIFT_W-1:0] n);
        return (ADDR_W'(1) << n) - ADDR_W'(1);
    endfunction

endpackage

// File: rtl/dmx_geom_decode.sv
module dmx_geom_decode
    import dmx_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic [CW-1:0] code,
    input  logic          wide,
    output geom_t         geom
);
    always_comb begin
        geom = decode_geom(code, wide);
    end
endmodule

// File: rtl/dmx_field_mux.sv
module dmx_field_mux
    import dmx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PIN_W,
    parameter int SW = SHIFT_W
) (
    input  logic [AW-1:0] addr,
    input  logic          wide,
    input  logic          ok,
    input  logic [SW-1:0] row_lsb,
    input  logic          row_phase,
    output logic [PW-1:0] pin
);
    logic [AW-1:0] eff;
    logic [AW-1:0] row_full;
    logic [AW-1:0] col_full;

    always_comb begin
        eff      = wide ? (addr >> 1) : addr;
        row_full = eff >> row_lsb;
        col_full = eff & ((AW'(1) << row_lsb) - AW'(1));
        if (!ok)
            pin = '0;
        else if (row_phase)
            pin = row_full[PW-1:0];
        else
            pin = col_full[PW-1:0];
    end
endmodule

// File: rtl/dmx_page_track.sv
module dmx_page_track
    import dmx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CODE_W,
    parameter int SW = SHIFT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] code,
    input  logic          wide,
    input  logic          ok,
    input  logic [SW-1:0] hit_lsb,
    input  logic          acc_valid,
    input  logic          page_close,
    output logic          hit
);
    logic [AW-1:0] tag_q;
    logic          vld_q;
    logic [CW-1:0] code_q;
    logic          wide_q;

    logic [AW-1:0] keep_mask;
    logic [AW-1:0] tag_now;
    logic          cfg_same;

    always_comb begin
        keep_mask = ~((AW'(1) << hit_lsb) - AW'(1));
        tag_now   = addr & keep_mask;
        cfg_same  = (code == code_q) && (wide == wide_q);
        hit       = acc_valid && ok && vld_q && cfg_same && (tag_now == tag_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            tag_q  <= '0;
            code_q <= '0;
            wide_q <= 1'b0;
        end else begin
            code_q <= code;
            wide_q <= wide;
            if (page_close) begin
                vld_q <= 1'b0;
            end else if (acc_valid && ok) begin
                vld_q <= 1'b1;
                tag_q <= tag_now;
            end else if (!cfg_same || (acc_valid && !ok)) begin
                vld_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dmx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PIN_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] page_code,
    input  logic          bus16,
    input  logic          acc_valid,
    input  logic          page_close,
    input  logic          row_phase,
    output logic [PW-1:0] pin_addr,
    output logic          page_hit,
    output logic          cfg_err
);
    localparam int SW = $clog2(AW);

    geom_t geom;

    dmx_geom_decode #(.CW(CW)) u_decode (
        .code (page_code),
        .wide (bus16),
        .geom (geom)
    );

    dmx_field_mux #(.AW(AW), .PW(PW), .SW(SW)) u_mux (
        .addr      (addr),
        .wide      (bus16),
        .ok        (geom.ok),
        .row_lsb   (geom.row_lsb),
        .row_phase (row_phase),
        .pin       (pin_addr)
    );

    dmx_page_track #(.AW(AW), .CW(CW), .SW(SW)) u_track (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .code       (page_code),
        .wide       (bus16),
        .ok         (geom.ok),
        .hit_lsb    (geom.hit_lsb),
        .acc_valid  (acc_valid),
        .page_close (page_close),
        .hit        (page_hit)
    );

    assign cfg_err = ~geom.ok;
endmodule

// File: rtl/dmx_checker.sv
module dmx_checker (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  page_code,
    input logic        bus16,
    input logic        acc_valid,
    input logic        page_close,
    input logic        row_phase,
    input logic [15:0] pin_addr,
    input logic        page_hit,
    input logic        cfg_err
);
    AST_RSV_FLAG: assert property (@(posedge clk) disable iff (rst)
        (page_code > 4'd3) == cfg_err); // R5
    AST_RSV_PIN_ZERO: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (pin_addr == 16'h0000 && !page_hit)); // R5
    AST_COL_NARROW: assert property (@(posedge clk) disable iff (rst)
        (!row_phase && !cfg_err) |-> (pin_addr[15:12] == 4'h0)); // R3
    AST_HIT_NEEDS_ACC: assert property (@(posedge clk) disable iff (rst)
        page_hit |-> acc_valid); // R7
    AST_CLOSE_MISS: assert property (@(posedge clk) disable iff (rst)
        page_close |=> !page_hit); // R8
    AST_CFG_CHANGE_MISS: assert property (@(posedge clk) disable iff (rst)
        (page_code != $past(page_code) || bus16 != $past(bus16)) |-> !page_hit); // R9

    always @(posedge clk) begin
        if (!rst && $past(rst)) begin
            AST_RESET_MISS: assert (!page_hit); // R10
        end
    end
endmodule

bind dram_addr_mux dmx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .page_code  (page_code),
    .bus16      (bus16),
    .acc_valid  (acc_valid),
    .page_close (page_close),
    .row_phase  (row_phase),
    .pin_addr   (pin_addr),
    .page_hit   (page_hit),
    .cfg_err    (cfg_err)
);

// File: tb/dram_addr_mux_bench.sv
module dram_addr_mux_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic [3:0]  page_code = '0;
    logic        bus16 = 1'b0;
    logic        acc_valid = 1'b0;
    logic        page_close = 1'b0;
    logic        row_phase = 1'b0;
    logic [15:0] pin_addr;
    logic        page_hit;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dram_addr_mux u_dram_addr_mux (
        .clk(clk), .rst(rst), .addr(addr), .page_code(page_code), .bus16(bus16),
        .acc_valid(acc_valid), .page_close(page_close), .row_phase(row_phase),
        .pin_addr(pin_addr), .page_hit(page_hit), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_pin(logic [31:0] a, logic [3:0] c, logic w, logic ph);
        int lsb;
        logic [31:0] e;
        if (c > 4'd3) return 16'h0;
        lsb = (c == 4'd3) ? 12 : 8 + int'(c);
        e = w ? (a >> 1) : a;
        if (ph) return 16'((e >> lsb) & 32'hFFFF);
        return 16'(e & ((32'd1 << lsb) - 32'd1));
    endfunction

    task automatic setup(input logic [3:0] c, input logic w);
        @(negedge clk);
        acc_valid = 1'b0; page_close = 1'b0;
        page_code = c; bus16 = w;
        @(negedge clk);
    endtask

    task automatic access(input logic [31:0] a, input logic exp_hit, input string req);
        @(negedge clk);
        addr = a; acc_valid = 1'b1;
        #1;
        check(req, 32'(page_hit), 32'(exp_hit));
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10 reset hit", 32'(page_hit), 0);
        check("R5 reset cfg_err", 32'(cfg_err), 0);
    endtask

    task automatic t_fields;
        logic [31:0] a = 32'hA5C3_9E71;
        for (int c = 0; c < 4; c++) begin
            for (int w = 0; w < 2; w++) begin
                setup(4'(c), 1'(w));
                addr = a;
                row_phase = 1'b1; #1;
                check(w ? "R2 R4 R1 row wide" : "R2 R1 row", 32'(pin_addr),
                      32'(model_pin(a, 4'(c), 1'(w), 1'b1)));
                row_phase = 1'b0; #1;
                check(w ? "R3 R4 R1 col wide" : "R3 R1 col", 32'(pin_addr),
                      32'(model_pin(a, 4'(c), 1'(w), 1'b0)));
                check("R5 cfg_err low", 32'(cfg_err), 0);
            end
        end
        setup(4'd0, 1'b0);
        addr = 32'h0012_34FF; row_phase = 1'b1; #1;
        check("R2 row code0 literal", 32'(pin_addr), 32'h1234);
        row_phase = 1'b0; #1;
        check("R3 col code0 literal", 32'(pin_addr), 32'h00FF);
    endtask

    task automatic t_reserved;
        setup(4'd0, 1'b0);
        access(32'h1111_2200, 1'b0, "R6 store before rsv");
        for (int c = 4; c < 16; c += 5) begin
            @(negedge clk);
            page_code = 4'(c); addr = 32'h1111_2200; acc_valid = 1'b1; row_phase = 1'b1;
            #1;
            check("R5 rsv cfg_err", 32'(cfg_err), 1);
            check("R5 rsv pin", 32'(pin_addr), 0);
            check("R5 rsv hit", 32'(page_hit), 0);
            acc_valid = 1'b0;
        end
        @(negedge clk);
        page_code = 4'd0;
    endtask

    task automatic t_hit8;
        setup(4'd0, 1'b0);
        access(32'h1234_5600, 1'b0, "R6 first miss");
        access(32'h1234_56FF, 1'b1, "R6 hit same 256 page");
        access(32'h1234_5700, 1'b0, "R6 miss next page");
        access(32'h1234_5780, 1'b1, "R6 hit new stored page");
        @(negedge clk); addr = 32'h1234_5780; acc_valid = 1'b0; #1;
        check("R7 no hit without acc", 32'(page_hit), 0);
        setup(4'd3, 1'b0);
        access(32'h0000_1000, 1'b0, "R1 4K first");
        access(32'h0000_1FFF, 1'b1, "R1 R6 4K hit");
        access(32'h0000_2000, 1'b0, "R1 R6 4K miss");
    endtask

    task automatic t_hit16;
        setup(4'd0, 1'b1);
        access(32'h1234_5600, 1'b0, "R6 wide first");
        access(32'h1234_57FF, 1'b1, "R6 wide hit bit8 ignored");
        access(32'h1234_5800, 1'b0, "R6 wide miss bit9");
        setup(4'd2, 1'b1);
        access(32'h0000_0000, 1'b0, "R6 wide 1K first");
        access(32'h0000_07FF, 1'b1, "R6 wide 1K hit");
        access(32'h0000_0800, 1'b0, "R6 wide 1K miss bit11");
    endtask

    task automatic t_close;
        setup(4'd1, 1'b0);
        access(32'h0000_4000, 1'b0, "R8 first");
        @(negedge clk); page_close = 1'b1;
        @(negedge clk); page_close = 1'b0;
        access(32'h0000_4001, 1'b0, "R8 miss after close");
        access(32'h0000_4002, 1'b1, "R8 hit after restore");
        @(negedge clk); addr = 32'h0000_4003; acc_valid = 1'b1; page_close = 1'b1;
        @(negedge clk); acc_valid = 1'b0; page_close = 1'b0;
        access(32'h0000_4004, 1'b0, "R8 close beats same-cycle access");
    endtask

    task automatic t_cfgchg;
        setup(4'd0, 1'b0);
        access(32'h0000_0100, 1'b0, "R9 first");
        @(negedge clk); page_code = 4'd1;
        @(negedge clk); page_code = 4'd0;
        @(negedge clk);
        access(32'h0000_0101, 1'b0, "R9 miss after code change");
        access(32'h0000_0102, 1'b1, "R9 hit after restore");
        @(negedge clk); bus16 = 1'b1; addr = 32'h0000_0102; acc_valid = 1'b1; #1;
        check("R9 miss in width change cycle", 32'(page_hit), 0);
        @(negedge clk); acc_valid = 1'b0;
        access(32'h0000_0103, 1'b1, "R9 hit on page stored in change cycle");
    endtask

    task automatic t_reset_mid;
        setup(4'd0, 1'b0);
        access(32'h0000_0900, 1'b0, "R10 first");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        access(32'h0000_0901, 1'b0, "R10 miss after reset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fields();
        t_reserved();
        t_hit8();
        t_hit16();
        t_close();
        t_cfgchg();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule